// File: doc/BRIEF.md
# Timing Margin Frequency Controller

This block closes a fast feedback loop between on-die slack sensors and a digitally controlled clock generator. Several delay-line sensors each report a short thermometer word that shows how much timing slack remains on a replica path. Every cycle, the block takes the poorest reading across all sensors and sorts it into a margin band. It then moves a frequency code so that the slack settles at the ideal band.

The response is deliberately lopsided. A reading that shows too little slack lowers the code by one step. A reading that shows no usable slack, or a corrupted word, drops the code by a fixed percentage of its present value in a single cycle. A reading that shows ample slack raises the code by one step, but only after that reading has lasted for a programmable number of cycles. The code is always kept within a programmable window. When the loop is switched off, the code returns to a programmed nominal value.

Top module: `slack_freq_ctrl`

## Requirements
- R1: Each sensor word is CODE_W bits wide, and bit CODE_W-1 is the written-first (leftmost) bit. For the default of 5 bits, the band output reports 4 for 11111 (ample slack), 3 for 11110, 2 for 11100 (ideal), 1 for 11000 (too little) and 0 for 10000 (none).
- R2: Any word that is not a run of ones starting at the leftmost bit and followed only by zeros is reported as band 0. This includes 00000.
- R3: The band output is the lowest band among all NSENS sensors. Only that band decides the next frequency code.
- R4: With the block enabled and band 1, the frequency code falls by exactly 1 at the next clock edge.
- R5: With the block enabled and band 0, the frequency code falls at the next clock edge by floor(code*DROP_PCT/100), or by 1 if that value is zero.
- R6: With the block enabled and band 2 or 3, the frequency code does not change.
- R7: With the block enabled, band 4 seen on holdoff+1 consecutive edges raises the code by 1 on the last of those edges. The wait count then restarts. Any other band, or the enable being low, clears the wait count.
- R8: While enabled, each new code is limited to the range f_min to f_max, given f_min <= f_max.
- R9: While rst is high or en is low, the code is loaded with f_nom at each clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Loop enable; low forces the nominal code |
| sens | input | NSENS*CODE_W | Packed sensor words; sensor s occupies bits [s*CODE_W +: CODE_W] |
| f_nom | input | FREQ_W | Nominal frequency code |
| f_min | input | FREQ_W | Lowest allowed code |
| f_max | input | FREQ_W | Highest allowed code |
| holdoff | input | HOLD_W | Extra cycles of ample slack needed before a raise |
| freq_code | output | FREQ_W | Current frequency code |
| band | output | 3 | Worst-case margin band (encoding in R1) |

## Verification
The bench builds the block with five 5-bit sensors, a 12-bit frequency code, a 4-bit hold-off and a 7 percent drop. The nominal code is 1000, inside a window of 600 to 1200. With a 4-bit hold-off, every wait length from zero to fifteen can be tested, including runs of ample slack broken by other bands. A 600 to 1200 window lets repeated drops reach the lower limit within a few cycles, and a long run of raises reach the upper limit. Random sensor mixes with occasional corrupted words test worst-case selection and invalid-word handling across the full code range.

// File: rtl/slack_freq_ctrl.sv
`timescale 1ns/1ps
module slack_freq_ctrl #(
  parameter int NSENS    = 5,
  parameter int CODE_W   = 5,
  parameter int FREQ_W   = 12,
  parameter int HOLD_W   = 8,
  parameter int DROP_PCT = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [NSENS*CODE_W-1:0] sens,
  input  logic [FREQ_W-1:0]       f_nom,
  input  logic [FREQ_W-1:0]       f_min,
  input  logic [FREQ_W-1:0]       f_max,
  input  logic [HOLD_W-1:0]       holdoff,
  output logic [FREQ_W-1:0]       freq_code,
  output logic [2:0]              band
);
  localparam int PW = FREQ_W + 8;
  localparam logic [2:0] B_NONE  = 3'd0;
  localparam logic [2:0] B_SMALL = 3'd1;
  localparam logic [2:0] B_LARGE = 3'(CODE_W - 1);

  function automatic logic [2:0] classify(input logic [CODE_W-1:0] c);
    int   n;
    logic run;
    n   = 0;
    run = 1'b1;
    for (int i = CODE_W - 1; i >= 0; i--) begin
      if (run && c[i]) n++;
      else run = 1'b0;
    end
    if (n == 0) return B_NONE;
    if (c != ~({CODE_W{1'b1}} >> n)) return B_NONE;
    return 3'(n - 1);
  endfunction

  always_comb begin
    logic [2:0] w;
    w = B_LARGE;
    for (int s = 0; s < NSENS; s++) begin
      if (classify(sens[s*CODE_W +: CODE_W]) < w) w = classify(sens[s*CODE_W +: CODE_W]);
    end
    band = w;
  end

  logic [HOLD_W-1:0] cnt;
  logic              up;
  logic [PW-1:0]     cur, prod, quot, dec, lo, hi, cand;
  logic [FREQ_W-1:0] nxt;

  assign up   = (band == B_LARGE) && (cnt == holdoff);
  assign cur  = PW'(freq_code);
  assign lo   = PW'(f_min);
  assign hi   = PW'(f_max);
  assign prod = cur * PW'(DROP_PCT);
  assign quot = prod / PW'(100);
  assign dec  = (quot == '0) ? PW'(1) : quot;

  always_comb begin
    if (band == B_NONE)       cand = (cur > dec) ? cur - dec : '0;
    else if (band == B_SMALL) cand = (cur > '0) ? cur - PW'(1) : '0;
    else if (up)              cand = cur + PW'(1);
    else                      cand = cur;
  end

  assign nxt = (cand < lo) ? f_min : (cand > hi) ? f_max : cand[FREQ_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      freq_code <= f_nom;
      cnt       <= '0;
    end else begin
      freq_code <= nxt;
      if (band != B_LARGE || up) cnt <= '0;
      else                       cnt <= cnt + 1'b1;
    end
  end

  // R9
  nominal_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> freq_code == $past(f_nom));

  // R8
  window_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (en && f_min <= f_max) |=> (freq_code >= $past(f_min) && freq_code <= $past(f_max)));

  // R4
  single_down_chk: assert property (@(posedge clk) disable iff (rst)
    (en && band == B_SMALL && freq_code > f_min && freq_code <= f_max)
      |=> freq_code == $past(freq_code) - 1'b1);

  // R5
  droop_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (en && band == B_NONE && freq_code <= f_max && f_min <= f_max)
      |=> (freq_code < $past(freq_code) || freq_code == $past(f_min)));

  // R6
  hold_band_chk: assert property (@(posedge clk) disable iff (rst)
    (en && band > B_SMALL && band < B_LARGE && freq_code >= f_min && freq_code <= f_max)
      |=> $stable(freq_code));

  // R7
  slow_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (en && freq_code >= f_min && freq_code <= f_max)
      |=> freq_code <= $past(freq_code) + 1'b1);

  // R3
  band_range_chk: assert property (@(posedge clk) disable iff (rst)
    band <= B_LARGE);
endmodule

// File: tb/test_slack_freq_ctrl.sv
`timescale 1ns/1ps
module test_slack_freq_ctrl;
  localparam int NS = 5;
  localparam int CW = 5;
  localparam int FW = 12;
  localparam int HW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic [NS*CW-1:0] sens = '0;
  logic [FW-1:0] f_nom = 12'd1000, f_min = 12'd600, f_max = 12'd1200;
  logic [HW-1:0] holdoff = '0;
  logic [FW-1:0] freq_code;
  logic [2:0]    band;

  int total = 0, bad = 0;
  int exp_f = 1000, exp_cnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  slack_freq_ctrl #(.NSENS(NS), .CODE_W(CW), .FREQ_W(FW), .HOLD_W(HW), .DROP_PCT(7)) i_slack_freq_ctrl (
    .clk(clk), .rst(rst), .en(en), .sens(sens), .f_nom(f_nom), .f_min(f_min),
    .f_max(f_max), .holdoff(holdoff), .freq_code(freq_code), .band(band));

  function automatic int cls(input logic [CW-1:0] c);
    case (c)
      5'b11111: return 4;
      5'b11110: return 3;
      5'b11100: return 2;
      5'b11000: return 1;
      default:  return 0;
    endcase
  endfunction

  function automatic int worst(input logic [NS*CW-1:0] v);
    int m = 4;
    for (int s = 0; s < NS; s++) if (cls(v[s*CW +: CW]) < m) m = cls(v[s*CW +: CW]);
    return m;
  endfunction

  function automatic logic [CW-1:0] code_of(input int b);
    case (b)
      4: return 5'b11111;
      3: return 5'b11110;
      2: return 5'b11100;
      1: return 5'b11000;
      default: return 5'b10000;
    endcase
  endfunction

  task automatic all_same(input logic [CW-1:0] c);
    for (int s = 0; s < NS; s++) sens[s*CW +: CW] = c;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_band(input string tag);
    #1;
    check(tag, int'(band), worst(sens));
  endtask

  task automatic tick(input string tag);
    int b, d, c;
    if (rst || !en) begin
      exp_f = int'(f_nom); exp_cnt = 0;
    end else begin
      b = worst(sens);
      c = exp_f;
      if (b == 0) begin
        d = (exp_f * 7) / 100;
        if (d == 0) d = 1;
        c = (exp_f > d) ? exp_f - d : 0;
        exp_cnt = 0;
      end else if (b == 1) begin
        c = (exp_f > 0) ? exp_f - 1 : 0;
        exp_cnt = 0;
      end else if (b == 4) begin
        if (exp_cnt == int'(holdoff)) begin c = exp_f + 1; exp_cnt = 0; end
        else exp_cnt++;
      end else exp_cnt = 0;
      if (c < int'(f_min)) c = int'(f_min);
      else if (c > int'(f_max)) c = int'(f_max);
      exp_f = c;
    end
    @(posedge clk);
    #2;
    check(tag, int'(freq_code), exp_f);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    all_same(5'b11100);
    tick("R9 reset");
    tick("R9 reset");
    rst = 1'b0;
    check("R9 reset value", int'(freq_code), 1000);
    en = 1'b1;

    for (int b = 0; b <= 4; b++) begin
      all_same(code_of(b));
      #1 check("R1 band code", int'(band), b);
    end
    all_same(5'b10100); chk_band("R2 invalid 10100");
    check("R2 invalid 10100 band", int'(band), 0);
    all_same(5'b01111); chk_band("R2 invalid 01111");
    all_same(5'b00000); chk_band("R2 invalid 00000");

    all_same(5'b11100); chk_band("R6 ideal");
    tick("R6 ideal hold");
    sens[2*CW +: CW] = 5'b11110; tick("R6 some hold");
    check("R6 hold value", int'(freq_code), 1000);

    all_same(5'b11111); sens[3*CW +: CW] = 5'b11000;
    chk_band("R3 worst of mix");
    tick("R4 small step");
    check("R4 small step value", int'(freq_code), 999);

    sens[4*CW +: CW] = 5'b10000;
    tick("R5 droop");
    check("R5 droop value", int'(freq_code), 930);
    sens[4*CW +: CW] = 5'b11010;
    chk_band("R2 corrupt word");
    tick("R5 corrupt drop");
    for (int k = 0; k < 12; k++) tick("R8 down to min");
    check("R8 min clamp", int'(freq_code), 600);

    holdoff = 4'd3;
    all_same(5'b11111);
    for (int k = 0; k < 3; k++) tick("R7 waiting");
    check("R7 no early raise", int'(freq_code), 600);
    tick("R7 raise");
    check("R7 raise value", int'(freq_code), 601);
    tick("R7 restart"); tick("R7 restart");
    all_same(5'b11110); tick("R7 break");
    all_same(5'b11111);
    for (int k = 0; k < 3; k++) tick("R7 after break");
    check("R7 cleared wait", int'(freq_code), 601);
    tick("R7 raise again");

    holdoff = 4'd0;
    f_max = 12'd605;
    for (int k = 0; k < 8; k++) tick("R8 up to max");
    check("R8 max clamp", int'(freq_code), 605);

    en = 1'b0; tick("R9 disabled");
    check("R9 disabled value", int'(freq_code), 1000);
    en = 1'b1; f_max = 12'd1200;

    for (int n = 0; n < 4000; n++) begin
      int base;
      base = $urandom_range(4, 0);
      if ($urandom_range(3, 0) != 0 && base < 2) base = base + 2;
      for (int s = 0; s < NS; s++)
        sens[s*CW +: CW] = code_of(base + $urandom_range(4 - base, 0));
      if ($urandom_range(15, 0) == 0) sens[$urandom_range(NS-1, 0)*CW +: CW] = CW'($urandom);
      if ($urandom_range(49, 0) == 0) en = ~en;
      if ($urandom_range(199, 0) == 0) holdoff = HW'($urandom);
      if ($urandom_range(299, 0) == 0) begin
        f_min = FW'($urandom_range(700, 400));
        f_max = FW'($urandom_range(1300, 800));
      end
      chk_band("R3 random worst");
      tick("R8 random step");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule